// File: doc/BRIEF.md
# Intra Mode Cost Comparator

This block selects intra prediction modes from SATD costs computed elsewhere. Costs arrive one per strobe. Each carries a mode index and a category tag. The block keeps a running minimum for each of three categories: 4x4 luma with nine modes, 16x16 luma with four modes, and chroma with four modes. A start pulse clears all three minima before a new macroblock.

Once every cost is in, a compare pulse launches a five-step sequence on one shared add/subtract unit. The first three steps build twenty-four times the penalty from the penalty shifted left by three. The fourth step adds the best 4x4 cost. The fifth step subtracts that sum from the best 16x16 cost. The sign and value of the result choose the luma partitioning. A one-cycle done flag reports the choice.

Top module: `intra_mode_picker`

## Requirements
- R1: `best4` holds the index (0..8) of the lowest 4x4 cost accepted since the last start. Category code 0 marks a 4x4 cost.
- R2: `best16` holds the index (0..3) of the lowest 16x16 cost accepted since the last start. Category code 1 marks a 16x16 cost.
- R3: `bestc` holds the index (0..3) of the lowest chroma cost accepted since the last start. Category code 2 marks a chroma cost.
- R4: When a new cost equals the current minimum of its category, the lower mode index is kept, whichever order the two arrive in.
- R5: A strobe has no effect on any output in three cases: category code 3, a 4x4 mode index above 8, or a 16x16 or chroma mode index above 3.
- R6: A start pulse clears all three trackers. The first accepted cost of each category after start becomes that category's minimum whatever its value. Start overrides a strobe in the same cycle.
- R7: Once the sequence ends, `use4x4` is 1 exactly when best16 − (best4 + 24·penalty) is greater than zero. Otherwise it is 0, so equality selects 16x16. `use4x4` changes only in the cycle in which `done` is high.
- R8: After the clock edge that samples `cmp_go`, `done` is high for exactly one cycle, following the fifth clock edge counted from the sampling edge.
- R9: A `cmp_go` pulse that arrives while a sequence is running is ignored and produces no extra done pulse.
- R10: After reset, all mode outputs, `use4x4` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the minimum trackers |
| cost_vld | input | 1 | Strobe for the cost, mode and category inputs |
| cost | input | COST_W | SATD cost |
| mode | input | 4 | Mode index of the cost |
| cat | input | 2 | Category: 0 = 4x4, 1 = 16x16, 2 = chroma, 3 = none |
| penalty | input | COST_W-5 | Penalty weight; must be held steady during a sequence |
| cmp_go | input | 1 | Starts the partition compare |
| best4 | output | 4 | Chosen 4x4 mode |
| best16 | output | 2 | Chosen 16x16 mode |
| bestc | output | 2 | Chosen chroma mode |
| use4x4 | output | 1 | 1 selects 4x4 partitioning, 0 selects 16x16 |
| done | output | 1 | One-cycle flag marking the end of the compare |

## Verification
The bench builds the block with the default COST_W of 18, which gives a 13-bit penalty and a 19-bit accumulator. At that width, costs of 262143 and a penalty of 8191 sit at the limits. This shows that best4 + 24·penalty does not wrap, and that the borrow from the final subtraction gives the correct sign. The bench also runs small costs, where the margin of 1 separates a strict win from a tie.

// File: rtl/intra_mode_picker.sv
module intra_mode_picker #(
  parameter int COST_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cost_vld,
  input  logic [COST_W-1:0] cost,
  input  logic [3:0]        mode,
  input  logic [1:0]        cat,
  input  logic [COST_W-6:0] penalty,
  input  logic              cmp_go,
  output logic [3:0]        best4,
  output logic [1:0]        best16,
  output logic [1:0]        bestc,
  output logic              use4x4,
  output logic              done
);
  localparam int ACC_W = COST_W + 1;
  localparam int PEN_W = COST_W - 5;

  logic [COST_W-1:0] c4_cost, c16_cost, cc_cost;
  logic              has4, has16, hasc;
  logic [ACC_W-1:0]  acc;
  logic [2:0]        phase;
  logic [ACC_W:0]    sum;
  logic [ACC_W-1:0]  pen8, addend;

  wire take4  = cost_vld && cat == 2'd0 && mode <= 4'd8 &&
                (!has4 || cost < c4_cost || (cost == c4_cost && mode < best4));
  wire take16 = cost_vld && cat == 2'd1 && mode <= 4'd3 &&
                (!has16 || cost < c16_cost || (cost == c16_cost && mode[1:0] < best16));
  wire takec  = cost_vld && cat == 2'd2 && mode <= 4'd3 &&
                (!hasc || cost < cc_cost || (cost == cc_cost && mode[1:0] < bestc));
  wire busy   = phase != 3'd0;

  assign pen8   = ACC_W'({penalty, 3'b000});
  assign addend = (phase == 3'd4) ? ACC_W'(c4_cost) : pen8;
  assign sum    = (phase == 3'd5) ? ({2'b00, c16_cost} - {1'b0, acc})
                                  : ({1'b0, acc} + {1'b0, addend});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {has4, has16, hasc} <= '0;
      c4_cost <= '0; c16_cost <= '0; cc_cost <= '0;
      best4 <= '0; best16 <= '0; bestc <= '0;
    end else if (start) begin
      {has4, has16, hasc} <= '0;
    end else begin
      if (take4)  begin has4  <= 1'b1; c4_cost  <= cost; best4  <= mode;      end
      if (take16) begin has16 <= 1'b1; c16_cost <= cost; best16 <= mode[1:0]; end
      if (takec)  begin hasc  <= 1'b1; cc_cost  <= cost; bestc  <= mode[1:0]; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0; acc <= '0; use4x4 <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        3'd0: if (cmp_go) begin acc <= pen8; phase <= 3'd2; end
        3'd2, 3'd3, 3'd4: begin acc <= sum[ACC_W-1:0]; phase <= phase + 3'd1; end
        3'd5: begin
          use4x4 <= !sum[ACC_W] && sum != '0;
          done   <= 1'b1;
          phase  <= 3'd0;
        end
        default: phase <= 3'd0;
      endcase
    end
  end
endmodule

module intra_mode_picker_chk #(
  parameter int COST_W = 18
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cost_vld,
  input logic       cmp_go,
  input logic [3:0] best4,
  input logic [1:0] best16,
  input logic [1:0] bestc,
  input logic       use4x4,
  input logic       done
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmp_go, 5));
  assert_best4_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    best4 <= 4'd8);
  assert_modes_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cost_vld && !start) |=> ($stable(best4) && $stable(best16) && $stable(bestc)));
  assert_decision_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (use4x4 != $past(use4x4)) |-> done);
endmodule

bind intra_mode_picker intra_mode_picker_chk #(.COST_W(COST_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cost_vld(cost_vld), .cmp_go(cmp_go),
  .best4(best4), .best16(best16), .bestc(bestc), .use4x4(use4x4), .done(done));

// File: tb/intra_mode_picker_test.sv
module intra_mode_picker_test;
  localparam int COST_W = 18;
  logic clk = 0, rst_n = 0, start = 0, cost_vld = 0, cmp_go = 0;
  logic [COST_W-1:0] cost = '0;
  logic [3:0] mode = '0;
  logic [1:0] cat = '0;
  logic [COST_W-6:0] penalty = '0;
  logic [3:0] best4;
  logic [1:0] best16, bestc;
  logic use4x4, done;
  int total = 0, bad = 0;

  intra_mode_picker #(.COST_W(COST_W)) uut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int c, int m, int k);
    @(negedge clk); cost = COST_W'(c); mode = 4'(m); cat = 2'(k); cost_vld = 1;
    @(negedge clk); cost_vld = 0;
  endtask

  task automatic clear();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic t_reset();
    chk("R10 best4", best4, 0); chk("R10 best16", best16, 0);
    chk("R10 bestc", bestc, 0); chk("R10 use4x4", use4x4, 0); chk("R10 done", done, 0);
  endtask

  task automatic t_mins();
    clear();
    for (int i = 0; i < 9; i++) send(500 - (i == 6 ? 300 : i * 10), i, 0);
    chk("R1 best4", best4, 6);
    send(90, 0, 1); send(40, 1, 1); send(70, 2, 1); send(41, 3, 1);
    chk("R2 best16", best16, 1);
    send(30, 0, 2); send(20, 1, 2); send(25, 2, 2); send(5, 3, 2);
    chk("R3 bestc", bestc, 3);
  endtask

  task automatic t_ties();
    clear(); send(77, 5, 0); send(77, 2, 0);
    chk("R4 tie later-lower", best4, 2);
    clear(); send(77, 2, 0); send(77, 5, 0);
    chk("R4 tie earlier-lower", best4, 2);
    clear(); send(9, 3, 1); send(9, 1, 1);
    chk("R4 tie 16x16", best16, 1);
  endtask

  task automatic t_ignored();
    clear(); send(100, 4, 0); send(100, 2, 1); send(100, 1, 2);
    send(1, 0, 3); send(1, 9, 0); send(1, 12, 1); send(1, 7, 2);
    chk("R5 best4", best4, 4); chk("R5 best16", best16, 2); chk("R5 bestc", bestc, 1);
  endtask

  task automatic t_clear();
    clear(); send(10, 1, 0); clear(); send(200000, 7, 0);
    chk("R6 first after start", best4, 7);
    @(negedge clk); start = 1; cost = 1; mode = 3; cat = 0; cost_vld = 1;
    @(negedge clk); start = 0; cost_vld = 0;
    send(150000, 5, 0);
    chk("R6 start over strobe", best4, 5);
  endtask

  task automatic go_and_check(string req, int exp);
    @(negedge clk); cmp_go = 1;
    @(negedge clk); cmp_go = 0;
    repeat (3) @(negedge clk);
    chk({req, " done early"}, done, 0);
    @(negedge clk);
    chk({req, " done"}, done, 1);
    chk({req, " use4x4"}, use4x4, exp);
    @(negedge clk);
    chk({req, " done width"}, done, 0);
  endtask

  task automatic decide(int c4, int c16, int p, int exp, string req);
    clear(); send(c4, 0, 0); send(c16, 0, 1);
    penalty = (COST_W-5)'(p);
    go_and_check(req, exp);
  endtask

  task automatic t_decide();
    decide(1000, 1241, 10, 1, "R7 strict win");
    decide(1000, 1240, 10, 0, "R7 equal");
    decide(1000, 1000, 10, 0, "R7 16x16 cheaper");
    decide(0, 1, 0, 1, "R7 zero penalty");
    decide(262143, 262143, 8191, 0, "R7 max values");
    decide(3, 262143, 8191, 1, "R7 large penalty");
  endtask

  task automatic t_busy_go();
    decide(50, 10, 0, 0, "R8 setup");
    @(negedge clk); cmp_go = 1;
    @(negedge clk); cmp_go = 0;
    @(negedge clk); cmp_go = 1;
    @(negedge clk); cmp_go = 0;
    @(negedge clk);
    @(negedge clk); chk("R8 done pulse", done, 1);
    repeat (3) begin @(negedge clk); chk("R9 no extra done", done, 0); end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_mins();
    t_ties();
    t_ignored();
    t_clear();
    t_decide();
    t_busy_go();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule